// File: doc/BRIEF.md
# Multi-bank GPIO interrupt controller

This block is a general-purpose I/O controller built from a parameterised number of banks. Each bank serves up to 32 lines and has eight 32-bit registers. They set the output value, the drive direction, open-drain behaviour, the interrupt trigger type and the interrupt enable, and they hold a sticky event status that software clears by writing ones. The block does not drive the pads itself. It produces an output-value vector and an output-enable vector, and it samples an input vector through a two-stage synchroniser.

Each line can raise an event on a rising edge, a falling edge, either edge, a high level or a low level. Three per-bank bit vectors select the trigger type: polarity, both-edges and level. The polarity bit chooses the active sense in both edge and level modes. A line's event is pending when its status bit and its enable bit are both set. One interrupt output is the OR of every pending line in every bank. Software reaches the registers through a plain word-addressed write strobe and a combinational read port.

The asynchronous active-low reset is released to the core through a two-flop synchroniser, so the core leaves reset on the second rising clock edge after the reset input goes high.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the direction register of every bank reads ones on every existing line. All other registers read 0, `irq` is 0 and every `gpio_oe` bit is 0.
- R2: A direction bit of 0 makes its line an output: `gpio_oe` is 1 and `gpio_out` follows the data bit. A direction bit of 1 makes it an input with `gpio_oe` at 0. Reading the data register returns the synchronised pin for input lines and the written value for output lines.
- R3: With the open-drain bit (word offset 0) at 1, `gpio_out` is 0 and the line is driven only when it is an output whose data bit is 0.
- R4: With level (offset 6) and both-edges (offset 4) at 0, the line latches its status bit (offset 7) on a falling edge when polarity (offset 3) is 0, and on a rising edge when polarity is 1.
- R5: With level at 0 and both-edges at 1, either edge latches the status bit whatever the polarity.
- R6: With level at 1, the status bit is set on every cycle the pin is low (polarity 0) or high (polarity 1). A clear written while that level is present has no lasting effect.
- R7: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. No other cause lowers a status bit.
- R8: `irq` is 1 exactly when some line in some bank has both its status bit and its enable bit (offset 5) at 1.
- R9: Register bits at or above a bank's width read 0. A bank's lines occupy consecutive bits of the pin vectors, starting just above the lines of the bank before it.
- R10: Register r of bank b sits at word address 8*b + r, with offsets 0 open-drain, 1 data, 2 direction, 3 polarity, 4 both-edges, 5 enable, 6 level, 7 status. Addresses of banks that do not exist read 0, and writes to them change nothing.
- R11: A pin change presented between clock edges sets its status bit at the third rising edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address: bank in the upper bits, register in the low three bits |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| gpio_in | input | sum of bank widths | Pin input samples, banks packed upward from bit 0 |
| gpio_out | output | sum of bank widths | Output value to the pads |
| gpio_oe | output | sum of bank widths | Output enable to the pads |
| irq | output | 1 | Combined interrupt |

## Verification
The trigger logic is tried with directed pin transitions for each mode: rising, falling, both edges, active-high level and active-low level. Each transition pattern mixes lines that toggle against lines that hold, so a detector that swaps polarity, misses one direction or treats a level as an edge gives a different status word. Random trials pick the polarity, both-edges, level and enable vectors freely per bank, from random old and new pin words, and the expected status comes from the old and new values alone. This separates the mode combinations, the level re-latch across a clear, and the masked-off bits above the narrower bank's width. A single-line timing probe tells apart a detector that is one register short or one register long.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int LINE_MAX = 32;
  localparam int WFIELD   = 6;
  localparam int BANK_MAX = 16;

  typedef enum logic [2:0] {
    REG_OPENDRAIN = 3'd0,
    REG_DATA      = 3'd1,
    REG_DIR       = 3'd2,
    REG_POL       = 3'd3,
    REG_BOTH      = 3'd4,
    REG_MASK      = 3'd5,
    REG_LEVEL     = 3'd6,
    REG_STATUS    = 3'd7
  } reg_idx_e;

  function automatic int bank_w(input logic [BANK_MAX*WFIELD-1:0] ws, input int b);
    return int'(ws[b*WFIELD +: WFIELD]);
  endfunction

  function automatic int bank_off(input logic [BANK_MAX*WFIELD-1:0] ws, input int b);
    int s;
    s = 0;
    for (int i = 0; i < b; i++) s += int'(ws[i*WFIELD +: WFIELD]);
    return s;
  endfunction

  function automatic logic [LINE_MAX-1:0] ones_below(input int w);
    if (w >= LINE_MAX) return '1;
    return (32'd1 << w) - 32'd1;
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] both,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] hit
);

  logic [W-1:0] prev_q;
  logic [W-1:0] prev_n;
  logic [W-1:0] rise;
  logic [W-1:0] fall;
  logic [W-1:0] edge_hit;
  logic [W-1:0] lvl_hit;

  always_comb begin
    prev_n   = smp;
    rise     = smp & ~prev_q;
    fall     = ~smp & prev_q;
    // both-edges overrides polarity; otherwise polarity picks the direction
    edge_hit = (both & (rise | fall)) | (~both & ((pol & rise) | (~pol & fall)));
    // level mode: active while the sample equals the polarity bit
    lvl_hit  = ~(smp ^ pol);
    hit      = (lvl & lvl_hit) | (~lvl & edge_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_n;
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_idx,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   rd_idx,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] oden_o,
  output logic         pend_any
);

  localparam int NCFG = 7;

  logic [7:0][W-1:0] regs_v;
  logic [NCFG-1:0]   cfg_en;
  logic [W-1:0]      smp;
  logic [W-1:0]      hit;
  logic [W-1:0]      clr;
  logic [W-1:0]      stat_q;
  logic [W-1:0]      stat_n;
  logic [W-1:0]      data_view;

  // configuration registers 0..6, each with its own write enable
  for (genvar k = 0; k < NCFG; k++) begin : g_cfg
    localparam logic [W-1:0] RST_VAL = (k == int'(REG_DIR)) ? '1 : '0;
    logic [W-1:0] q;
    assign cfg_en[k] = wr_en && (wr_idx == 3'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q <= RST_VAL;
      else if (cfg_en[k]) q <= wr_data;
    end
    assign regs_v[k] = q;
  end
  assign regs_v[7] = stat_q;

  gpio_sync2 #(.W(W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (smp)
  );

  gpio_evt_detect #(.W(W)) u_det (
    .clk  (clk),
    .rst_n(rst_n),
    .smp  (smp),
    .pol  (regs_v[REG_POL]),
    .both (regs_v[REG_BOTH]),
    .lvl  (regs_v[REG_LEVEL]),
    .hit  (hit)
  );

  // status: write-one-to-clear, a new event in the same cycle wins
  always_comb begin
    clr = '0;
    if (wr_en && (wr_idx == REG_STATUS)) clr = wr_data;
    stat_n = (stat_q & ~clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_n;
  end

  always_comb begin
    data_view = (regs_v[REG_DIR] & smp) | (~regs_v[REG_DIR] & regs_v[REG_DATA]);
    if (rd_idx == REG_DATA) rd_data = data_view;
    else                    rd_data = regs_v[rd_idx];
  end

  assign pad_out  = regs_v[REG_DATA] & ~regs_v[REG_OPENDRAIN];
  assign pad_oe   = ~regs_v[REG_DIR] & ~(regs_v[REG_OPENDRAIN] & regs_v[REG_DATA]);
  assign stat_o   = stat_q;
  assign mask_o   = regs_v[REG_MASK];
  assign dir_o    = regs_v[REG_DIR];
  assign oden_o   = regs_v[REG_OPENDRAIN];
  assign pend_any = |(stat_q & regs_v[REG_MASK]);

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter logic [NUM_BANKS*WFIELD-1:0] BANK_WIDTHS = {6'd20, 6'd32},
  parameter int ADDR_W = 5,
  localparam logic [BANK_MAX*WFIELD-1:0] WS = (BANK_MAX*WFIELD)'(BANK_WIDTHS),
  localparam int TOTAL = bank_off(WS, NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [TOTAL-1:0]  gpio_in,
  output logic [TOTAL-1:0]  gpio_out,
  output logic [TOTAL-1:0]  gpio_oe,
  output logic              irq
);

  localparam int BSEL_W = ADDR_W - 3;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [BSEL_W-1:0] bank_no;
  logic [2:0]        reg_idx;
  logic [31:0]       bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] pend_vec;
  logic [TOTAL-1:0]  stat_flat;
  logic [TOTAL-1:0]  mask_flat;
  logic [TOTAL-1:0]  dir_flat;
  logic [TOTAL-1:0]  oden_flat;
  logic              stat_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign bank_no = reg_addr[ADDR_W-1:3];
  assign reg_idx = reg_addr[2:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BW  = bank_w(WS, b);
    localparam int OFF = bank_off(WS, b);
    logic [BW-1:0] rd_w;

    gpio_bank #(.W(BW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .wr_en   (reg_we && (32'(bank_no) == b)),
      .wr_idx  (reg_idx),
      .wr_data (reg_wdata[BW-1:0]),
      .rd_idx  (reg_idx),
      .rd_data (rd_w),
      .pad_in  (gpio_in[OFF +: BW]),
      .pad_out (gpio_out[OFF +: BW]),
      .pad_oe  (gpio_oe[OFF +: BW]),
      .stat_o  (stat_flat[OFF +: BW]),
      .mask_o  (mask_flat[OFF +: BW]),
      .dir_o   (dir_flat[OFF +: BW]),
      .oden_o  (oden_flat[OFF +: BW]),
      .pend_any(pend_vec[b])
    );

    if (BW < LINE_MAX) begin : g_pad
      assign bank_rd[b] = {{(LINE_MAX-BW){1'b0}}, rd_w};
    end else begin : g_full
      assign bank_rd[b] = rd_w;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (32'(bank_no) == b) reg_rdata = bank_rd[b];
    end
  end

  assign stat_wr = reg_we && (reg_idx == REG_STATUS) && (32'(bank_no) < NUM_BANKS);
  assign irq     = |pend_vec;

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter logic [NUM_BANKS*WFIELD-1:0] BANK_WIDTHS = {6'd20, 6'd32},
  parameter int ADDR_W = 5,
  localparam logic [BANK_MAX*WFIELD-1:0] WS = (BANK_MAX*WFIELD)'(BANK_WIDTHS),
  localparam int TOTAL = bank_off(WS, NUM_BANKS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic [TOTAL-1:0]  gpio_out,
  input logic [TOTAL-1:0]  gpio_oe,
  input logic              irq,
  input logic [TOTAL-1:0]  stat_flat,
  input logic [TOTAL-1:0]  mask_flat,
  input logic [TOTAL-1:0]  dir_flat,
  input logic [TOTAL-1:0]  oden_flat,
  input logic              stat_wr
);

  logic [31:0] rd_mask;
  logic        rd_valid;

  always_comb begin
    rd_mask  = '0;
    rd_valid = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (32'(reg_addr[ADDR_W-1:3]) == b) begin
        rd_valid = 1'b1;
        rd_mask  = ones_below(bank_w(WS, b));
      end
    end
  end

  assert_oe_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_oe & dir_flat) == '0);

  assert_odrain_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_out & oden_flat) == '0);

  assert_clear_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(stat_flat) & ~stat_flat)) |-> $past(stat_wr));

  assert_irq_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(stat_flat & mask_flat)));

  assert_rd_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((reg_rdata & ~rd_mask) == '0));

  assert_rd_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (reg_rdata == '0));

endmodule

bind gpio_irq_ctrl gpio_irq_chk #(
  .NUM_BANKS  (NUM_BANKS),
  .BANK_WIDTHS(BANK_WIDTHS),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_addr (reg_addr),
  .reg_rdata(reg_rdata),
  .gpio_out (gpio_out),
  .gpio_oe  (gpio_oe),
  .irq      (irq),
  .stat_flat(stat_flat),
  .mask_flat(mask_flat),
  .dir_flat (dir_flat),
  .oden_flat(oden_flat),
  .stat_wr  (stat_wr)
);

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;

  localparam int AW  = 5;
  localparam int TOT = 52;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           reg_we;
  logic [AW-1:0]  reg_addr;
  logic [31:0]    reg_wdata;
  logic [31:0]    reg_rdata;
  logic [TOT-1:0] gpio_in;
  logic [TOT-1:0] gpio_out;
  logic [TOT-1:0] gpio_oe;
  logic           irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_ctrl u_gpio_irq_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .gpio_in  (gpio_in),
    .gpio_out (gpio_out),
    .gpio_oe  (gpio_oe),
    .irq      (irq)
  );

  function automatic int bw(input int b);
    return (b == 0) ? 32 : 20;
  endfunction

  function automatic logic [31:0] wmask(input int b);
    return (bw(b) >= 32) ? 32'hFFFF_FFFF : ((32'd1 << bw(b)) - 32'd1);
  endfunction

  function automatic logic [31:0] exp_stat(input int b, input logic [31:0] o_in, input logic [31:0] n_in,
                                           input logic [31:0] pol, input logic [31:0] both,
                                           input logic [31:0] lvl);
    logic [31:0] r;
    logic [31:0] o;
    logic [31:0] n;
    o = o_in & wmask(b);
    n = n_in & wmask(b);
    for (int i = 0; i < 32; i++) begin
      if (lvl[i])       r[i] = pol[i] ? (o[i] | n[i]) : (~o[i] | ~n[i]);
      else if (both[i]) r[i] = o[i] ^ n[i];
      else if (pol[i])  r[i] = ~o[i] & n[i];
      else              r[i] = o[i] & ~n[i];
    end
    return r & wmask(b);
  endfunction

  function automatic logic [31:0] pins_out(input int b);
    return (b == 0) ? gpio_out[31:0] : {12'd0, gpio_out[51:32]};
  endfunction

  function automatic logic [31:0] pins_oe(input int b);
    return (b == 0) ? gpio_oe[31:0] : {12'd0, gpio_oe[51:32]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int b, input int r, input logic [31:0] d);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_addr  = AW'(b*8 + r);
    reg_wdata = d;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    #1;
    d = reg_rdata;
  endtask

  task automatic setpins(input int b, input logic [31:0] v);
    @(negedge clk);
    if (b == 0) gpio_in[31:0]  = v;
    else        gpio_in[51:32] = v[19:0];
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // configure one bank, present old then new pins, check status and irq
  task automatic trial(input int b, input logic [31:0] pol, input logic [31:0] both,
                       input logic [31:0] lvl, input logic [31:0] msk,
                       input logic [31:0] o, input logic [31:0] n, input string tag);
    logic [31:0] got;
    logic [31:0] e;
    wr(b, 2, 32'hFFFF_FFFF);
    wr(b, 0, 32'h0);
    wr(b, 3, pol);
    wr(b, 4, both);
    wr(b, 6, lvl);
    wr(b, 5, msk);
    wr(1 - b, 5, 32'h0);
    setpins(b, o);
    waitc(5);
    wr(b, 7, 32'hFFFF_FFFF);
    setpins(b, n);
    waitc(5);
    e = exp_stat(b, o, n, pol, both, lvl);
    rd(b*8 + 7, got);
    chk({tag, " status"}, got, e);
    chk({"R8 irq after ", tag}, {31'd0, irq}, {31'd0, |(e & msk)});
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_1234));
    rst_n     = 1'b0;
    reg_we    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    gpio_in   = '0;
    waitc(3);
    @(negedge clk);
    rst_n = 1'b1;
    waitc(4);

    // R1 reset state
    for (int b = 0; b < 2; b++) begin
      for (int r = 0; r < 8; r++) begin
        rd(b*8 + r, v);
        chk($sformatf("R1 bank%0d reg%0d", b, r), v, (r == 2) ? wmask(b) : 32'h0);
      end
      chk("R1 oe", pins_oe(b), 32'h0);
    end
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2 outputs, direction, data readback
    wr(0, 1, 32'hA5A5_5A5A);
    wr(0, 2, 32'hFFFF_0000);
    chk("R2 out", pins_out(0), 32'hA5A5_5A5A);
    chk("R2 oe", pins_oe(0), 32'h0000_FFFF);
    @(negedge clk);
    gpio_in[31:0] = 32'h1234_5678;
    waitc(3);
    rd(1, v);
    chk("R2 data readback", v, 32'h1234_5A5A);

    // R3 open-drain
    wr(0, 0, 32'h0000_00FF);
    chk("R3 out", pins_out(0), 32'hA5A5_5A00);
    chk("R3 oe", pins_oe(0), 32'h0000_FFA5);

    // R9 narrow bank
    wr(1, 1, 32'hFFFF_FFFF);
    wr(1, 2, 32'h0);
    rd(9, v);
    chk("R9 data width", v, 32'h000F_FFFF);
    chk("R9 out width", pins_out(1), 32'h000F_FFFF);
    chk("R9 oe width", pins_oe(1), 32'h000F_FFFF);
    wr(1, 2, 32'hFFFF_FFFF);
    rd(10, v);
    chk("R9 dir width", v, 32'h000F_FFFF);

    // R10 unmapped bank
    wr(0, 2, 32'hFFFF_FFFF);
    wr(0, 0, 32'h0);
    wr(2, 2, 32'h0);
    rd(18, v);
    chk("R10 unmapped read", v, 32'h0);
    rd(2, v);
    chk("R10 bank0 dir untouched", v, 32'hFFFF_FFFF);

    // directed trigger modes
    trial(0, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'hF0F0_F0F0, "R4 rising");
    trial(1, 32'h0, 32'h0, 32'h0, 32'h0, 32'h000F_FFFF, 32'h0000_00FF, "R4 falling");
    trial(0, 32'hAAAA_5555, 32'hFFFF_FFFF, 32'h0, 32'h0000_000F, 32'h0F0F, 32'h00FF, "R5 both");
    trial(0, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h4, 32'h3, 32'h5, "R6 level high");
    wr(0, 7, 32'hFFFF_FFFF);
    rd(7, v);
    chk("R6 R7 clear under active level", v, 32'h5);
    wr(0, 7, 32'h0);
    rd(7, v);
    chk("R7 zero write keeps status", v, 32'h5);
    trial(1, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, "R6 level low");

    // random mixes
    for (int t = 0; t < 40; t++) begin
      trial(t % 2, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, "R4 R5 R6 random");
    end

    // R11 latency on one line
    wr(0, 3, 32'h1);
    wr(0, 4, 32'h0);
    wr(0, 6, 32'h0);
    wr(0, 5, 32'h1);
    wr(1, 5, 32'h0);
    setpins(0, 32'h0);
    waitc(5);
    wr(0, 7, 32'hFFFF_FFFF);
    chk("R11 idle", {31'd0, irq}, 32'd0);
    @(negedge clk);
    gpio_in[0] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R11 not before third edge", {31'd0, irq}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R11 at third edge", {31'd0, irq}, 32'd1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule